// File: doc/BRIEF.md
# External Interrupt and Event Line Controller

The controller watches a vector of asynchronous input lines and turns selected transitions on each of them into two kinds of output: a level interrupt request that stays raised until software acknowledges it, and a one-cycle event strobe. Each line is handled on its own. It has its own choice of active edges (rising, falling or both), its own interrupt enable, its own event enable, a latched pending flag and a software trigger bit that injects a request through the same path as a detected edge.

Software reaches the configuration and status through a small word-addressed register port. Writes take effect on the clock edge where `reg_req_i` and `reg_we_i` are both high. Reads are combinational from `reg_addr_i`. The interrupt vector is meant for a downstream priority controller. The event vector can wake or kick other logic without involving software.

Top module: `extline_ctrl`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` and `evt_o` are 0.
- R2: With a line's rising-edge bit and its interrupt enable bit set, a 0-to-1 change on that input sets the line's pending flag. `irq_o` for that line goes high on the third rising clock edge after the input changes: two synchroniser stages, then the edge detector.
- R3: A falling-edge bit makes 1-to-0 changes qualify. With both bits set, both directions qualify. A direction whose bit is clear never sets the pending flag.
- R4: When a line's interrupt enable bit (offset 3) is 0, a qualifying request leaves its pending flag and `irq_o` bit at 0.
- R5: When a line's event enable bit (offset 4) is 1, each qualifying request drives that `evt_o` bit high for exactly one clock cycle, at the same edge that would set the pending flag. When the bit is 0, the request produces no event, and the interrupt path still works.
- R6: The pending flags read at offset 5. Hardware never clears them. Writing 1 to a bit at offset 5 clears it, and writing 0 leaves it unchanged.
- R7: A write to the rising-edge register (offset 0) or the falling-edge register (offset 1) clears the pending flag of every line whose bit changes value in that write. Lines whose bit is rewritten with the same value keep their pending flag.
- R8: Writing 1 to a bit of the software trigger register (offset 2) that currently reads 0 raises a request on that line at the write edge. The bit then reads 1 until a clear of that line's pending flag (by R6 or R7), and it clears then. Writing 1 to a bit that already reads 1 raises no new request.
- R9: If a request and a clear reach the same pending flag in the same cycle, the flag ends up set.
- R10: Register offsets are: 0 rising-edge enables, 1 falling-edge enables, 2 software trigger, 3 interrupt enables, 4 event enables, 5 pending. Offsets 6 and 7 read 0 and ignore writes. Bit i of every register belongs to line i.
- R11: Lines are independent. A change on one input, or an enable on one line, never affects another line's flags or outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | NUM_LINES | Asynchronous external input lines |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Write enable, qualified by reg_req_i |
| reg_addr_i | input | 3 | Register word offset |
| reg_wdata_i | input | NUM_LINES | Write data, bit i for line i |
| reg_rdata_o | output | NUM_LINES | Read data for reg_addr_i |
| irq_o | output | NUM_LINES | Per-line interrupt request (pending flag) |
| evt_o | output | NUM_LINES | Per-line one-cycle event strobe |

## Verification
The bench times an input change against the three-edge latency and checks that the request is still low one cycle before it rises. A design with one synchroniser stage too few or too many fails that check. It places a pending clear on exactly the cycle where an edge is detected: a design that lets the clear win drops an interrupt. It rewrites a polarity register with both unchanged and changed bits, which catches a design that clears every pending flag on any polarity write or that ignores polarity changes. It counts event strobes over a window, so a stretched or repeated pulse is caught, and it also checks that the software trigger bit persists and then clears together with its pending flag.

// File: rtl/extline_pkg.sv
package extline_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_RISE   = 3'd0,
    REG_FALL   = 3'd1,
    REG_SWTRIG = 3'd2,
    REG_IRQEN  = 3'd3,
    REG_EVTEN  = 3'd4,
    REG_PEND   = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/extline_sync.sv
module extline_sync #(
  parameter int unsigned N      = 23,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] prev_o
);
  // STAGES synchroniser flops plus one history flop per line
  for (genvar g = 0; g < N; g++) begin : g_line
    logic [STAGES:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-1:0], async_i[g]};
    end
    assign level_o[g] = chain_q[STAGES-1];
    assign prev_o[g]  = chain_q[STAGES];
  end
endmodule

// File: rtl/extline_edge.sv
module extline_edge #(
  parameter int unsigned N = 23
) (
  input  logic [N-1:0] level_i,
  input  logic [N-1:0] prev_i,
  input  logic [N-1:0] rise_en_i,
  input  logic [N-1:0] fall_en_i,
  output logic [N-1:0] hit_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic rise, fall;
    assign rise     = level_i[g] & ~prev_i[g];
    assign fall     = ~level_i[g] & prev_i[g];
    assign hit_o[g] = (rise & rise_en_i[g]) | (fall & fall_en_i[g]);
  end
endmodule

// File: rtl/extline_regs.sv
module extline_regs
  import extline_pkg::*;
#(
  parameter int unsigned N = 23
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  input  logic [N-1:0]      hw_hit_i,
  output logic [N-1:0]      rdata_o,
  output logic [N-1:0]      rise_en_o,
  output logic [N-1:0]      fall_en_o,
  output logic [N-1:0]      irq_o,
  output logic [N-1:0]      evt_o
);
  logic [N-1:0] rise_q, fall_q, swi_q, irq_en_q, evt_en_q, pend_q, evt_q;
  logic [N-1:0] pol_chg, clr, sw_hit, trig;
  logic         wr, wr_rise, wr_fall, wr_sw, wr_irqen, wr_evten, wr_pend;

  assign wr       = req_i & we_i;
  assign wr_rise  = wr && (addr_i == REG_RISE);
  assign wr_fall  = wr && (addr_i == REG_FALL);
  assign wr_sw    = wr && (addr_i == REG_SWTRIG);
  assign wr_irqen = wr && (addr_i == REG_IRQEN);
  assign wr_evten = wr && (addr_i == REG_EVTEN);
  assign wr_pend  = wr && (addr_i == REG_PEND);

  // polarity change on a line drops its pending flag
  assign pol_chg = (wr_rise ? (wdata_i ^ rise_q) : '0)
                 | (wr_fall ? (wdata_i ^ fall_q) : '0);
  assign clr     = (wr_pend ? wdata_i : '0) | pol_chg;
  assign sw_hit  = wr_sw ? (wdata_i & ~swi_q) : '0;
  assign trig    = hw_hit_i | sw_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_q   <= '0;
      fall_q   <= '0;
      irq_en_q <= '0;
      evt_en_q <= '0;
      swi_q    <= '0;
      pend_q   <= '0;
      evt_q    <= '0;
    end else begin
      if (wr_rise)  rise_q   <= wdata_i;
      if (wr_fall)  fall_q   <= wdata_i;
      if (wr_irqen) irq_en_q <= wdata_i;
      if (wr_evten) evt_en_q <= wdata_i;
      swi_q  <= (swi_q & ~clr) | sw_hit;
      pend_q <= (pend_q & ~clr) | (trig & irq_en_q); // set wins
      evt_q  <= trig & evt_en_q;
    end
  end

  always_comb begin
    unique case (addr_i)
      REG_RISE:   rdata_o = rise_q;
      REG_FALL:   rdata_o = fall_q;
      REG_SWTRIG: rdata_o = swi_q;
      REG_IRQEN:  rdata_o = irq_en_q;
      REG_EVTEN:  rdata_o = evt_en_q;
      REG_PEND:   rdata_o = pend_q;
      default:    rdata_o = '0;
    endcase
  end

  assign rise_en_o = rise_q;
  assign fall_en_o = fall_q;
  assign irq_o     = pend_q;
  assign evt_o     = evt_q;

  p_pend_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_pend && !wr_rise && !wr_fall) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  p_pend_needs_irqen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(irq_en_q)) == '0));

  p_evt_needs_evten_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((evt_q & ~$past(evt_en_q)) == '0));

  p_swi_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_pend && !wr_rise && !wr_fall) |=> ((swi_q & $past(swi_q)) == $past(swi_q)));

  p_no_stray_evt_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_hit_i == '0 && !wr_sw) |=> (evt_q == '0));
endmodule

// File: rtl/extline_ctrl.sv
module extline_ctrl
  import extline_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 23,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] line_i,
  input  logic                 reg_req_i,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [NUM_LINES-1:0] reg_wdata_i,
  output logic [NUM_LINES-1:0] reg_rdata_o,
  output logic [NUM_LINES-1:0] irq_o,
  output logic [NUM_LINES-1:0] evt_o
);
  logic [NUM_LINES-1:0] level, prev, hit, rise_en, fall_en;

  extline_sync #(.N(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (line_i),
    .level_o (level),
    .prev_o  (prev)
  );

  extline_edge #(.N(NUM_LINES)) u_edge (
    .level_i   (level),
    .prev_i    (prev),
    .rise_en_i (rise_en),
    .fall_en_i (fall_en),
    .hit_o     (hit)
  );

  extline_regs #(.N(NUM_LINES)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (reg_req_i),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .hw_hit_i  (hit),
    .rdata_o   (reg_rdata_o),
    .rise_en_o (rise_en),
    .fall_en_o (fall_en),
    .irq_o     (irq_o),
    .evt_o     (evt_o)
  );
endmodule

// File: tb/sim_extline_ctrl.sv
module sim_extline_ctrl;
  localparam int N = 23;
  localparam logic [N-1:0] ALL = '1;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] line_i = '0;
  logic         reg_req_i = 1'b0, reg_we_i = 1'b0;
  logic [2:0]   reg_addr_i = '0;
  logic [N-1:0] reg_wdata_i = '0;
  logic [N-1:0] reg_rdata_o, irq_o, evt_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  extline_ctrl #(.NUM_LINES(N)) u0 (.*);

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk_i);
    reg_req_i = 1'b1; reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_req_i = 1'b0; reg_we_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [N-1:0] exp);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 chk(req, reg_rdata_o, exp);
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic t_reset;
    for (int a = 0; a < 6; a++) rd_chk("R1", 3'(a), '0);
    chk("R1", irq_o, '0);
    chk("R1", evt_o, '0);
  endtask

  task automatic t_rise;
    wr(3, ALL);
    wr(0, 23'h1);
    @(negedge clk_i); line_i[0] = 1'b1;
    cyc(2); chk("R2", irq_o, '0);
    cyc(1); chk("R2", irq_o, 23'h1);
    wr(5, 23'h1);
    chk("R6", irq_o, '0);
    line_i[0] = 1'b0;
    cyc(4); chk("R3", irq_o, '0);
  endtask

  task automatic t_fall;
    wr(1, 23'h2);
    @(negedge clk_i); line_i[1] = 1'b1;
    cyc(4); chk("R3", irq_o, '0);
    line_i[1] = 1'b0;
    cyc(3); chk("R3", irq_o, 23'h2);
    wr(5, 23'h2);
    wr(0, 23'h2);
    @(negedge clk_i); line_i[1] = 1'b1;
    cyc(3); chk("R3", irq_o, 23'h2);
    wr(5, 23'h2);
    line_i[1] = 1'b0;
    cyc(3); chk("R3", irq_o, 23'h2);
    wr(5, 23'h2);
  endtask

  task automatic t_event;
    int cnt;
    wr(3, '0); wr(4, 23'h4); wr(0, 23'h4); wr(1, '0);
    @(negedge clk_i); line_i[2] = 1'b1;
    cnt = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      if (evt_o[2]) cnt++;
    end
    chk("R5", N'(cnt), N'(1));
    chk("R4", irq_o, '0);
    rd_chk("R4", 5, '0);
    line_i[2] = 1'b0;
    cyc(3);
    wr(4, '0); wr(3, ALL);
    @(negedge clk_i); line_i[2] = 1'b1;
    cnt = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      if (evt_o != '0) cnt++;
    end
    chk("R5", N'(cnt), '0);
    chk("R5", irq_o, 23'h4);
    wr(5, 23'h4);
    line_i[2] = 1'b0;
    cyc(3);
  endtask

  task automatic t_w1c;
    wr(2, 23'h18);
    rd_chk("R8", 5, 23'h18);
    wr(5, '0);
    cyc(5);
    rd_chk("R6", 5, 23'h18);
    wr(5, 23'h08);
    rd_chk("R6", 5, 23'h10);
    rd_chk("R8", 2, 23'h10);
    wr(5, 23'h10);
    rd_chk("R6", 5, '0);
  endtask

  task automatic t_swtrig;
    wr(4, 23'h20);
    wr(2, 23'h20);
    chk("R8", evt_o, 23'h20);
    chk("R8", irq_o, 23'h20);
    @(negedge clk_i); chk("R5", evt_o, '0);
    wr(2, 23'h20);
    chk("R8", evt_o, '0);
    rd_chk("R8", 2, 23'h20);
    wr(5, 23'h20);
    rd_chk("R8", 2, '0);
    wr(4, '0);
  endtask

  task automatic t_polarity;
    wr(0, '0); wr(1, '0);
    wr(2, 23'h40);
    wr(0, '0);
    rd_chk("R7", 5, 23'h40);
    wr(1, 23'h40);
    rd_chk("R7", 5, '0);
    rd_chk("R8", 2, '0);
    wr(2, 23'h40);
    wr(0, 23'h1);
    rd_chk("R7", 5, 23'h40);
    wr(5, 23'h40);
    wr(1, '0);
  endtask

  task automatic t_set_wins;
    wr(2, 23'h1);
    chk("R9", irq_o, 23'h1);
    @(negedge clk_i); line_i[0] = 1'b1;
    @(negedge clk_i);
    wr(5, 23'h1);
    chk("R9", irq_o, 23'h1);
    rd_chk("R8", 2, '0);
    wr(5, 23'h1);
    chk("R6", irq_o, '0);
    line_i[0] = 1'b0;
    cyc(3);
  endtask

  task automatic t_map;
    wr(6, ALL);
    rd_chk("R10", 6, '0);
    rd_chk("R10", 7, '0);
    rd_chk("R10", 3, ALL);
    rd_chk("R10", 0, 23'h1);
  endtask

  task automatic t_indep;
    wr(0, 23'h200);
    @(negedge clk_i); line_i[9] = 1'b1; line_i[10] = 1'b1;
    cyc(3); chk("R11", irq_o, 23'h200);
    wr(5, ALL);
    chk("R11", irq_o, '0);
  endtask

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    t_reset();
    t_rise();
    t_fall();
    t_event();
    t_w1c();
    t_swtrig();
    t_polarity();
    t_set_wins();
    t_map();
    t_indep();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule